// File: doc/BRIEF.md
# Two-Word Instruction Decoder

The block turns a stream of 16-bit instruction words for a small 8-bit RISC microcontroller into a registered, decoded record. Each record holds an operation code and the operand fields that the word carries: destination register, source register, immediate, bit index, signed relative offset and absolute target. Words come in one per cycle under a valid strobe. The record appears one clock later together with a one-cycle decode-valid pulse.

Register fields in several formats are narrower than five bits and are widened into fixed register windows. One window is registers 16 to 31, a second is 16 to 23, and a third is the even registers 24 to 30. Absolute jump and call need two words. The first word is held in a pending stage and produces no record. The next accepted word, whatever its bit pattern, supplies the low 16 bits of a 22-bit target. The record for the absolute instruction comes out only after that second word. A word that fits no known pattern yields an illegal record with all operand fields at zero.

Top module: `insn_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, dec_valid_o is 0, every output field is 0 and op_o is 0. Reset also clears any pending first word of an absolute instruction, so the next word is decoded on its own.
- R2: The op_o codes in decimal are:
  - 1 add, 2 add with carry, 3 word add immediate, 4 subtract, 5 subtract immediate, 6 subtract with carry, 7 subtract with carry immediate, 8 word subtract immediate
  - 9 and, 10 and immediate, 11 or, 12 or immediate, 13 exclusive or
  - 14 complement, 15 negate, 16 increment, 17 decrement
  - 18 unsigned multiply, 19 signed multiply, 20 signed-by-unsigned multiply, 21 fractional unsigned, 22 fractional signed, 23 fractional signed-by-unsigned
  - 24 relative jump, 25 indirect jump, 26 extended indirect jump, 27 absolute jump, 28 relative call, 29 indirect call, 30 extended indirect call, 31 absolute call
  - 32 return, 33 return from interrupt
  - 34 compare-skip-if-equal, 35 compare, 36 compare with carry, 37 compare immediate
  - 38 skip if register bit clear, 39 skip if register bit set, 40 skip if I/O bit clear, 41 skip if I/O bit set
  - 42 branch if status bit set, 43 branch if status bit clear
  - 44 illegal
  
  Fields that an operation does not use are 0.
- R3: The two-register group is selected by the top six bits. They are 000001 compare with carry, 000010 subtract with carry, 000011 add, 000100 compare-skip-if-equal, 000101 compare, 000110 subtract, 000111 add with carry, 001000 and, 001001 exclusive or, 001010 or, and 100111 unsigned multiply. For this group rd_o is bits 8:4 and rr_o is {bit 9, bits 3:0}.
- R4: The top nibble selects the byte-immediate group: 0011 compare, 0100 subtract with carry, 0101 subtract, 0110 or, 0111 and. For this group rd_o is 16 plus bits 7:4 and imm_o is {bits 11:8, bits 3:0}.
- R5: The high bytes 0x96 (word add) and 0x97 (word subtract) select the word-immediate group. For this group rd_o is 24 + 2*bits 5:4 and imm_o is {00, bits 7:6, bits 3:0}.
- R6: High byte 0x02 is signed multiply, with rd_o = 16 + bits 7:4 and rr_o = 16 + bits 3:0. High byte 0x03 is the mixed group, with rd_o = 16 + bits 6:4 and rr_o = 16 + bits 2:0. In the mixed group, {bit 7, bit 3} = 00 gives 20, 01 gives 21, 10 gives 22 and 11 gives 23.
- R7: Words 1001010r_rrrrnnnn carry rd_o from bits 8:4, and the low nibble nnnn picks the operation: 0000 complement, 0001 negate, 0011 increment, 1010 decrement. The exact words 0x9409, 0x9419, 0x9509, 0x9519, 0x9508 and 0x9518 decode to 25, 26, 29, 30, 32 and 33, each with all fields 0.
- R8: Top nibble 1100 (jump) and 1101 (call) are relative, with rel_o taken from bits 11:0.
- R9: Prefix 111100 (branch if set) and 111101 (branch if clear) carry rel_o as bits 9:3 sign-extended to 12 bits, and bit_o from bits 2:0.
- R10: Words 1111110r_rrrr0bbb and 1111111r_rrrr0bbb are the register-bit skips: clear and set. They give rr_o from bits 8:4 and bit_o from bits 2:0. If bit 3 of such a word is 1, the word is illegal. High bytes 0x99 (clear) and 0x9B (set) are the I/O-bit skips, with imm_o = bits 7:3 and bit_o = bits 2:0.
- R11: Words 1001010x_xxxx110x (jump) and 1001010x_xxxx111x (call) are the first word of an absolute instruction. That word produces no dec_valid_o. One cycle after the next accepted word, dec_valid_o is 1, op_o is 27 or 31, and target_o = {first bits 8:4, first bit 0, second word}. All other fields are 0.
- R12: The word that follows a pending first word is taken only as target data, even if it matches another pattern. The word after that is decoded normally.
- R13: A word that matches no pattern gives dec_valid_o 1, illegal_o 1, op_o 44, and all operand fields at 0. illegal_o is 0 for every other record.
- R14: dec_valid_o is 1 exactly in the cycle after each accepted word, except an absolute first word, and 0 otherwise. Idle cycles between the two words of an absolute instruction keep the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | Instruction word strobe |
| word_i | input | 16 | Instruction word |
| dec_valid_o | output | 1 | Decoded record valid, one-cycle pulse |
| op_o | output | 6 | Operation code |
| rd_o | output | 5 | Destination register |
| rr_o | output | 5 | Source or tested register |
| imm_o | output | 8 | Immediate or I/O address |
| bit_o | output | 3 | Bit index |
| rel_o | output | 12 | Signed relative offset |
| target_o | output | 22 | Absolute target |
| illegal_o | output | 1 | Unmatched word |

## Verification
Target capture and normal decoding can fall in the same cycle. This happens when the word that completes an absolute instruction is itself a valid opcode, or is the first word of another absolute instruction. The bench provokes this by sending a call first word followed at once by a jump-pattern word, and then an add word, all in consecutive cycles. It judges the result on three points: the jump-pattern word must appear only in target_o, no record may be lost, and the add must decode normally in the following cycle. Reset during a pending state, idle gaps inside a pair, and the move from a field-rich record to an illegal one are checked as directed cases.

// File: rtl/insn_pkg.sv
package insn_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 8;
  localparam int BIT_W  = 3;
  localparam int REL_W  = 12;
  localparam int TGT_W  = 22;
  localparam int HI_W   = TGT_W - WORD_W;
  localparam int OP_W   = 6;
  localparam int BR_W   = 7;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 6'd0, OP_ADD, OP_ADC, OP_ADDW_IMM, OP_SUB, OP_SUB_IMM, OP_SBC,
    OP_SBC_IMM, OP_SUBW_IMM, OP_AND, OP_AND_IMM, OP_OR, OP_OR_IMM, OP_XOR,
    OP_NOT, OP_NEG, OP_INC, OP_DEC, OP_MUL_UU, OP_MUL_SS, OP_MUL_SU,
    OP_FMUL_UU, OP_FMUL_SS, OP_FMUL_SU, OP_JMP_REL, OP_JMP_IND,
    OP_JMP_IND_EXT, OP_JMP_ABS, OP_CALL_REL, OP_CALL_IND, OP_CALL_IND_EXT,
    OP_CALL_ABS, OP_RET, OP_RET_INT, OP_CMP_SKIP_EQ, OP_CMP, OP_CMP_CARRY,
    OP_CMP_IMM, OP_SKIP_RBIT_CLR, OP_SKIP_RBIT_SET, OP_SKIP_IOBIT_CLR,
    OP_SKIP_IOBIT_SET, OP_BR_SET, OP_BR_CLR, OP_ILLEGAL
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rr;
    logic [IMM_W-1:0] imm;
    logic [BIT_W-1:0] bitn;
    logic [REL_W-1:0] rel;
    logic [TGT_W-1:0] target;
    logic             illegal;
  } dec_rec_t;

  // register windows
  function automatic logic [REG_W-1:0] win_upper16(input logic [3:0] f);
    return {1'b1, f};
  endfunction

  function automatic logic [REG_W-1:0] win_mid8(input logic [2:0] f);
    return {2'b10, f};
  endfunction

  function automatic logic [REG_W-1:0] win_pairs(input logic [1:0] f);
    return {2'b11, f, 1'b0};
  endfunction
endpackage

// File: rtl/insn_classify.sv
module insn_classify
  import insn_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output dec_rec_t          rec_o,
  output logic              first_abs_o,
  output logic              abs_call_o,
  output logic [HI_W-1:0]   abs_hi_o
);
  logic [WORD_W-1:0] w;
  op_e op;
  logic fmt_two_reg, fmt_byte_imm;
  logic [REG_W-1:0] rd, rr;
  logic [IMM_W-1:0] imm;
  logic [BIT_W-1:0] bitn;
  logic [REL_W-1:0] rel;

  assign w = word_i;

  always_comb begin
    op = OP_ILLEGAL;
    fmt_two_reg = 1'b0;
    fmt_byte_imm = 1'b0;
    rd = '0;
    rr = '0;
    imm = '0;
    bitn = '0;
    rel = '0;
    first_abs_o = 1'b0;
    abs_call_o = 1'b0;
    casez (w)
      16'b1001_0100_0000_1001: op = OP_JMP_IND;
      16'b1001_0100_0001_1001: op = OP_JMP_IND_EXT;
      16'b1001_0101_0000_1001: op = OP_CALL_IND;
      16'b1001_0101_0001_1001: op = OP_CALL_IND_EXT;
      16'b1001_0101_0000_1000: op = OP_RET;
      16'b1001_0101_0001_1000: op = OP_RET_INT;
      16'b1001_010?_????_0000: begin op = OP_NOT; rd = w[8:4]; end
      16'b1001_010?_????_0001: begin op = OP_NEG; rd = w[8:4]; end
      16'b1001_010?_????_0011: begin op = OP_INC; rd = w[8:4]; end
      16'b1001_010?_????_1010: begin op = OP_DEC; rd = w[8:4]; end
      16'b1001_010?_????_110?: begin op = OP_JMP_ABS; first_abs_o = 1'b1; end
      16'b1001_010?_????_111?: begin
        op = OP_CALL_ABS;
        first_abs_o = 1'b1;
        abs_call_o = 1'b1;
      end
      16'b1001_0110_????_????, 16'b1001_0111_????_????: begin
        op  = w[8] ? OP_SUBW_IMM : OP_ADDW_IMM;
        rd  = win_pairs(w[5:4]);
        imm = {2'b00, w[7:6], w[3:0]};
      end
      16'b1001_11??_????_????: begin op = OP_MUL_UU; fmt_two_reg = 1'b1; end
      16'b1001_1001_????_????, 16'b1001_1011_????_????: begin
        op   = w[9] ? OP_SKIP_IOBIT_SET : OP_SKIP_IOBIT_CLR;
        imm  = {3'b000, w[7:3]};
        bitn = w[2:0];
      end
      16'b0000_0010_????_????: begin
        op = OP_MUL_SS;
        rd = win_upper16(w[7:4]);
        rr = win_upper16(w[3:0]);
      end
      16'b0000_0011_????_????: begin
        unique case ({w[7], w[3]})
          2'b00:   op = OP_MUL_SU;
          2'b01:   op = OP_FMUL_UU;
          2'b10:   op = OP_FMUL_SS;
          default: op = OP_FMUL_SU;
        endcase
        rd = win_mid8(w[6:4]);
        rr = win_mid8(w[2:0]);
      end
      16'b0000_01??_????_????: begin op = OP_CMP_CARRY;   fmt_two_reg = 1'b1; end
      16'b0000_10??_????_????: begin op = OP_SBC;         fmt_two_reg = 1'b1; end
      16'b0000_11??_????_????: begin op = OP_ADD;         fmt_two_reg = 1'b1; end
      16'b0001_00??_????_????: begin op = OP_CMP_SKIP_EQ; fmt_two_reg = 1'b1; end
      16'b0001_01??_????_????: begin op = OP_CMP;         fmt_two_reg = 1'b1; end
      16'b0001_10??_????_????: begin op = OP_SUB;         fmt_two_reg = 1'b1; end
      16'b0001_11??_????_????: begin op = OP_ADC;         fmt_two_reg = 1'b1; end
      16'b0010_00??_????_????: begin op = OP_AND;         fmt_two_reg = 1'b1; end
      16'b0010_01??_????_????: begin op = OP_XOR;         fmt_two_reg = 1'b1; end
      16'b0010_10??_????_????: begin op = OP_OR;          fmt_two_reg = 1'b1; end
      16'b0011_????_????_????: begin op = OP_CMP_IMM;     fmt_byte_imm = 1'b1; end
      16'b0100_????_????_????: begin op = OP_SBC_IMM;     fmt_byte_imm = 1'b1; end
      16'b0101_????_????_????: begin op = OP_SUB_IMM;     fmt_byte_imm = 1'b1; end
      16'b0110_????_????_????: begin op = OP_OR_IMM;      fmt_byte_imm = 1'b1; end
      16'b0111_????_????_????: begin op = OP_AND_IMM;     fmt_byte_imm = 1'b1; end
      16'b1100_????_????_????: begin op = OP_JMP_REL;  rel = w[11:0]; end
      16'b1101_????_????_????: begin op = OP_CALL_REL; rel = w[11:0]; end
      16'b1111_00??_????_????, 16'b1111_01??_????_????: begin
        op   = w[10] ? OP_BR_CLR : OP_BR_SET;
        rel  = {{(REL_W-BR_W){w[9]}}, w[9:3]};
        bitn = w[2:0];
      end
      16'b1111_11??_????_0???: begin
        op   = w[9] ? OP_SKIP_RBIT_SET : OP_SKIP_RBIT_CLR;
        rr   = w[8:4];
        bitn = w[2:0];
      end
      default: op = OP_ILLEGAL;
    endcase
    if (fmt_two_reg) begin
      rd = w[8:4];
      rr = {w[9], w[3:0]};
    end
    if (fmt_byte_imm) begin
      rd  = win_upper16(w[7:4]);
      imm = {w[11:8], w[3:0]};
    end
  end

  assign abs_hi_o = {w[8:4], w[0]};

  always_comb begin
    rec_o         = '0;
    rec_o.op      = op;
    rec_o.rd      = rd;
    rec_o.rr      = rr;
    rec_o.imm     = imm;
    rec_o.bitn    = bitn;
    rec_o.rel     = rel;
    rec_o.illegal = (op == OP_ILLEGAL);
  end

  // byte-immediate destinations always land in the upper window (R4)
  always_comb begin
    if (fmt_byte_imm) a_byte_imm_window_r4: assert (rec_o.rd[REG_W-1]);
  end
endmodule

// File: rtl/insn_join.sv
module insn_join
  import insn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              first_abs_i,
  input  logic              abs_call_i,
  input  logic [HI_W-1:0]   abs_hi_i,
  output logic              pending_o,
  output logic              fire_o,
  output dec_rec_t          rec_o
);
  logic            pending_q, call_q;
  logic [HI_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      call_q    <= 1'b0;
      hi_q      <= '0;
    end else if (word_valid_i) begin
      if (pending_q) begin
        pending_q <= 1'b0;
      end else if (first_abs_i) begin
        pending_q <= 1'b1;
        call_q    <= abs_call_i;
        hi_q      <= abs_hi_i;
      end
    end
  end

  assign pending_o = pending_q;
  assign fire_o    = word_valid_i && pending_q;

  always_comb begin
    rec_o        = '0;
    rec_o.op     = call_q ? OP_CALL_ABS : OP_JMP_ABS;
    rec_o.target = {hi_q, word_i};
  end

  p_pend_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !pending_q && first_abs_i) |=> pending_q);
  p_pend_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && pending_q) |=> !pending_q);
  p_pend_idle_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> $stable(pending_q) && $stable(hi_q));
endmodule

// File: rtl/insn_out_reg.sv
module insn_out_reg
  import insn_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  dec_rec_t rec_i,
  output logic     valid_o,
  output dec_rec_t rec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rec_o   <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) rec_o <= rec_i;
    end
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              dec_valid_o,
  output logic [OP_W-1:0]   op_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rr_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [REL_W-1:0]  rel_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              illegal_o
);
  dec_rec_t        cls_rec, join_rec, sel_rec, out_rec;
  logic            first_abs, abs_call, pending, fire, load;
  logic [HI_W-1:0] abs_hi;

  insn_classify u_classify (
    .word_i      (word_i),
    .rec_o       (cls_rec),
    .first_abs_o (first_abs),
    .abs_call_o  (abs_call),
    .abs_hi_o    (abs_hi)
  );

  insn_join u_join (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .first_abs_i  (first_abs),
    .abs_call_i   (abs_call),
    .abs_hi_i     (abs_hi),
    .pending_o    (pending),
    .fire_o       (fire),
    .rec_o        (join_rec)
  );

  // pending second word wins over classification
  assign sel_rec = fire ? join_rec : cls_rec;
  assign load    = word_valid_i && (pending || !first_abs);

  insn_out_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .rec_i   (sel_rec),
    .valid_o (dec_valid_o),
    .rec_o   (out_rec)
  );

  assign op_o      = out_rec.op;
  assign rd_o      = out_rec.rd;
  assign rr_o      = out_rec.rr;
  assign imm_o     = out_rec.imm;
  assign bit_o     = out_rec.bitn;
  assign rel_o     = out_rec.rel;
  assign target_o  = out_rec.target;
  assign illegal_o = out_rec.illegal;

  p_first_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && !pending && first_abs) |=> !dec_valid_o);
  p_join_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && pending) |=> dec_valid_o && target_o[WORD_W-1:0] == $past(word_i)
      && (op_o == OP_JMP_ABS || op_o == OP_CALL_ABS));
  p_idle_no_valid_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> !dec_valid_o);
  p_illegal_zero_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> op_o == OP_ILLEGAL && rd_o == '0 && rr_o == '0 && imm_o == '0
      && bit_o == '0 && rel_o == '0 && target_o == '0);
  p_legal_flag_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && op_o != OP_ILLEGAL) |-> !illegal_o);
endmodule

// File: tb/insn_decoder_tb_top.sv
module insn_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        dec_valid_o;
  logic [5:0]  op_o;
  logic [4:0]  rd_o, rr_o;
  logic [7:0]  imm_o;
  logic [2:0]  bit_o;
  logic [11:0] rel_o;
  logic [21:0] target_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  insn_decoder dut_i (
    .clk_i, .rst_ni, .word_valid_i, .word_i, .dec_valid_o, .op_o, .rd_o,
    .rr_o, .imm_o, .bit_o, .rel_o, .target_o, .illegal_o
  );

  // {word, op, rd, rr, imm, bit, rel}
  localparam int NV = 46;
  localparam logic [54:0] VEC [NV] = '{
    {16'h0E52, 6'd1,  5'd5,  5'd18, 8'h00, 3'd0, 12'h000},  // R3
    {16'h1C00, 6'd2,  5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h1800, 6'd4,  5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h0BFF, 6'd6,  5'd31, 5'd31, 8'h00, 3'd0, 12'h000},
    {16'h2000, 6'd9,  5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h2800, 6'd11, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h27FF, 6'd13, 5'd31, 5'd31, 8'h00, 3'd0, 12'h000},
    {16'h100F, 6'd34, 5'd0,  5'd15, 8'h00, 3'd0, 12'h000},
    {16'h1400, 6'd35, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h0400, 6'd36, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9D01, 6'd18, 5'd16, 5'd1,  8'h00, 3'd0, 12'h000},
    {16'h55AC, 6'd5,  5'd26, 5'd0,  8'h5C, 3'd0, 12'h000},  // R4
    {16'h4000, 6'd7,  5'd16, 5'd0,  8'h00, 3'd0, 12'h000},
    {16'h7FFF, 6'd10, 5'd31, 5'd0,  8'hFF, 3'd0, 12'h000},
    {16'h60F0, 6'd12, 5'd31, 5'd0,  8'h00, 3'd0, 12'h000},
    {16'h3F0F, 6'd37, 5'd16, 5'd0,  8'hFF, 3'd0, 12'h000},
    {16'h96FF, 6'd3,  5'd30, 5'd0,  8'h3F, 3'd0, 12'h000},  // R5
    {16'h9781, 6'd8,  5'd24, 5'd0,  8'h21, 3'd0, 12'h000},
    {16'h025E, 6'd19, 5'd21, 5'd30, 8'h00, 3'd0, 12'h000},  // R6
    {16'h0370, 6'd20, 5'd23, 5'd16, 8'h00, 3'd0, 12'h000},
    {16'h031A, 6'd21, 5'd17, 5'd18, 8'h00, 3'd0, 12'h000},
    {16'h03A3, 6'd22, 5'd18, 5'd19, 8'h00, 3'd0, 12'h000},
    {16'h03FF, 6'd23, 5'd23, 5'd23, 8'h00, 3'd0, 12'h000},
    {16'h9490, 6'd14, 5'd9,  5'd0,  8'h00, 3'd0, 12'h000},  // R7
    {16'h95F1, 6'd15, 5'd31, 5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9503, 6'd16, 5'd16, 5'd0,  8'h00, 3'd0, 12'h000},
    {16'h942A, 6'd17, 5'd2,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9409, 6'd25, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9419, 6'd26, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9509, 6'd29, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9519, 6'd30, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9508, 6'd32, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h9518, 6'd33, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'hCFFF, 6'd24, 5'd0,  5'd0,  8'h00, 3'd0, 12'hFFF},  // R8
    {16'hD7FF, 6'd28, 5'd0,  5'd0,  8'h00, 3'd0, 12'h7FF},
    {16'hF205, 6'd42, 5'd0,  5'd0,  8'h00, 3'd5, 12'hFC0},  // R9
    {16'hF5F8, 6'd43, 5'd0,  5'd0,  8'h00, 3'd0, 12'h03F},
    {16'hFC73, 6'd38, 5'd0,  5'd7,  8'h00, 3'd3, 12'h000},  // R10
    {16'hFFF7, 6'd39, 5'd0,  5'd31, 8'h00, 3'd7, 12'h000},
    {16'hFFFF, 6'd44, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},  // R10 bit3 set, R13
    {16'h99FA, 6'd40, 5'd0,  5'd0,  8'h1F, 3'd2, 12'h000},
    {16'h9B2E, 6'd41, 5'd0,  5'd0,  8'h05, 3'd6, 12'h000},
    {16'h0000, 6'd44, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},  // R13
    {16'hE123, 6'd44, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h940B, 6'd44, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000},
    {16'h2C00, 6'd44, 5'd0,  5'd0,  8'h00, 3'd0, 12'h000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk_i);
    word_valid_i = 1'b1;
    word_i = w;
    @(negedge clk_i);
    word_valid_i = 1'b0;
    word_i = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL R14 watchdog: got hung exp done");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 valid in reset", dec_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 valid", dec_valid_o, 0);
    chk("R1 op", op_o, 0);
    chk("R1 fields", {rd_o, rr_o, imm_o, bit_o, rel_o, target_o, illegal_o}, 0);

    // R2 R3 R4 R5 R6 R7 R8 R9 R10 R13 table walk
    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      v = VEC[i];
      send(v[54:39]);
      chk($sformatf("R2 valid w=%h", v[54:39]), dec_valid_o, 1);
      chk($sformatf("R2 op w=%h", v[54:39]), op_o, v[38:33]);
      chk($sformatf("R3 rd w=%h", v[54:39]), rd_o, v[32:28]);
      chk($sformatf("R3 rr w=%h", v[54:39]), rr_o, v[27:23]);
      chk($sformatf("R4 imm w=%h", v[54:39]), imm_o, v[22:15]);
      chk($sformatf("R9 bit w=%h", v[54:39]), bit_o, v[14:12]);
      chk($sformatf("R8 rel w=%h", v[54:39]), rel_o, v[11:0]);
      chk($sformatf("R13 target w=%h", v[54:39]), target_o, 0);
      chk($sformatf("R13 illegal w=%h", v[54:39]), illegal_o, v[38:33] == 6'd44);
    end

    // R14 idle cycle after a record
    @(negedge clk_i);
    chk("R14 idle valid", dec_valid_o, 0);

    // R11 absolute jump
    send(16'h955D);
    chk("R11 first word silent", dec_valid_o, 0);
    send(16'hBEEF);
    chk("R11 jump valid", dec_valid_o, 1);
    chk("R11 jump op", op_o, 27);
    chk("R11 jump target", target_o, 22'h2BBEEF);
    chk("R11 jump other fields", {rd_o, rr_o, imm_o, bit_o, rel_o, illegal_o}, 0);

    // R14 idle gap inside a call pair
    send(16'h940E);
    repeat (3) begin
      @(negedge clk_i);
      chk("R14 gap silent", dec_valid_o, 0);
    end
    send(16'h1234);
    chk("R14 gap call op", op_o, 31);
    chk("R14 gap call target", target_o, 22'h001234);

    // R12 back-to-back: call first, jump-pattern as data, then add
    @(negedge clk_i);
    word_valid_i = 1'b1;
    word_i = 16'h95FF;
    @(negedge clk_i);
    chk("R12 first silent", dec_valid_o, 0);
    word_i = 16'h940C;
    @(negedge clk_i);
    chk("R12 join valid", dec_valid_o, 1);
    chk("R12 join op", op_o, 31);
    chk("R12 join target", target_o, 22'h3F940C);
    word_i = 16'h0E52;
    @(negedge clk_i);
    word_valid_i = 1'b0;
    word_i = '0;
    chk("R12 next valid", dec_valid_o, 1);
    chk("R12 next op", op_o, 1);
    chk("R12 next rd", rd_o, 5);
    chk("R12 next target", target_o, 0);

    // R1 reset clears pending
    send(16'h940C);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(16'h0E52);
    chk("R1 post-reset valid", dec_valid_o, 1);
    chk("R1 post-reset op", op_o, 1);
    chk("R1 post-reset rr", rr_o, 18);
    chk("R1 post-reset target", target_o, 0);

    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule